// File: doc/BRIEF.md
# DRAM Reclock Command Sequencer

This block moves an external DRAM device to a new clock frequency. A start pulse hands it a memory-type code, the target contents of mode registers 0 to 2, and the contents those registers hold now, as read back from the device. The sequencer captures all of these at start. It then drives a fixed series of device commands through a valid/ready command port. Where the target disables the DLL, it first turns the DLL off. It then parks the device in self-refresh and asks for the clock change through a request/acknowledge pair. After that it brings the device out of self-refresh and rewrites only the mode registers whose value changes. It asks for the timing-register update through a second request/acknowledge pair. When the target enables the DLL, it finally resets and relocks the DLL.

All waits are counted in cycles where the `tick_i` input is high, so one tick marks one time unit. The wait lengths depend on the memory type. The sequencer ends every run with a one-cycle `done_o` pulse, or with a one-cycle `err_o` pulse when the memory type is not supported.

Top module: `dram_reclock_seq`

## Requirements
- R1: A start with memory-type code 3 (supported codes: 0 DDR2, 1 DDR3, 2 GDDR3) raises `err_o` for exactly one cycle, in the cycle after start. No command, request or `done_o` appears.
- R2: If the current MR1 has its DLL-off bit clear and the target MR1 has it set, the run opens with a precharge, then an MRS to MR1 carrying the current MR1 with the DLL-off bit set, then a wait of T_MRS ticks. The DLL-off bit is bit 6 for GDDR3 and bit 0 for the other types.
- R3: Self-refresh entry issues precharge, refresh, refresh, auto-refresh off and self-refresh enter, in that order. It then waits T_SRE_D3 ticks for DDR3 and zero ticks otherwise.
- R4: After entry, `clk_req_o` rises and stays high until `clk_ack_i` is seen. No command is issued while it is high.
- R5: After the clock acknowledge, the sequencer waits T_PREX ticks. It then issues precharge, self-refresh exit and auto-refresh on, and waits T_SRX_D3 ticks twice for DDR3 (zero otherwise).
- R6: MR2, then MR1, then MR0 are written, each only if its target differs from its current value, and each write is followed by T_MRS ticks. The MR1 value written is the target with the current DLL-off bit kept. The current MR2 is compared only for DDR3 and GDDR3; for DDR2, MR2 is never written in this phase.
- R7: After the mode-register phase, `tim_req_o` rises and stays high until `tim_ack_i` is seen.
- R8: If the target MR1 has the DLL-off bit clear, the DLL phase runs. When the current MR1 had the bit set, it first writes the target MR1 and waits T_MRS. It then writes MR0 as the target with bit 8 set, waits T_MRS, writes MR0 as the target with bit 8 clear, and waits T_MRS plus the DLL-lock time (T_LOCK_D2, T_LOCK_D3 or T_LOCK_G3 by type).
- R9: For GDDR3 only, a precharge follows the DLL phase.
- R10: Command codes are 0 precharge, 1 refresh, 2 auto-refresh off, 3 auto-refresh on, 4 self-refresh enter, 5 self-refresh exit and 6 MRS. `cmd_mr_o` holds the register index. While `cmd_valid_o` is high and `cmd_ready_i` is low, the valid signal and the payload hold.
- R11: Waits advance only on cycles where `tick_i` is high. A wait of length zero takes a single cycle.
- R12: A run ends with a one-cycle `done_o` pulse. Target and current values and the type are sampled at start. During a run, start and all data inputs are ignored.
- R13: While reset is asserted, and after it is released, the block is idle: no valid, request, done or error is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reclock run (taken only when idle) |
| mem_kind_i | input | 2 | Memory type: 0 DDR2, 1 DDR3, 2 GDDR3, 3 unsupported |
| tgt_mr0_i | input | 32 | Target MR0 |
| tgt_mr1_i | input | 32 | Target MR1 |
| tgt_mr2_i | input | 32 | Target MR2 |
| cur_mr0_i | input | 32 | Current MR0 |
| cur_mr1_i | input | 32 | Current MR1 |
| cur_mr2_i | input | 32 | Current MR2 |
| tick_i | input | 1 | One time unit elapsed |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command taken |
| cmd_code_o | output | 3 | Command code |
| cmd_mr_o | output | 2 | Mode-register index for MRS |
| cmd_data_o | output | 32 | Mode-register value for MRS |
| clk_req_o | output | 1 | Clock change request |
| clk_ack_i | input | 1 | Clock change finished |
| tim_req_o | output | 1 | Timing-register update request |
| tim_ack_i | input | 1 | Timing update finished |
| done_o | output | 1 | Run finished (one cycle) |
| err_o | output | 1 | Unsupported type (one cycle) |

## Verification
The hardest state to reach is a DLL that changes state across the reclock. Turning it off needs the extra precharge and MRS before self-refresh. Turning it back on needs the MR1 write that keeps the DLL-off bit, then the restoring MR1 write and the MR0 reset pair. The stimulus reaches both directions by choosing current and target MR1 values whose DLL-off bits differ, under each memory type. GDDR3 uses bit 6 rather than bit 0, so the bit choice is tested too. Stalls on `cmd_ready_i`, a start pulse in the middle of a run, and a reset in the middle of a run are overlaid on these runs.

// File: rtl/reclock_pkg.sv
package reclock_pkg;

  localparam int MRW = 32;
  localparam int TW  = 16;

  typedef enum logic [1:0] {
    MT_DDR2  = 2'd0,
    MT_DDR3  = 2'd1,
    MT_GDDR3 = 2'd2,
    MT_OTHER = 2'd3
  } mem_kind_e;

  typedef enum logic [2:0] {
    C_PRECHARGE = 3'd0,
    C_REFRESH   = 3'd1,
    C_AREF_OFF  = 3'd2,
    C_AREF_ON   = 3'd3,
    C_SREF_IN   = 3'd4,
    C_SREF_OUT  = 3'd5,
    C_MRS       = 3'd6,
    C_NOP       = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    K_CMD  = 3'd0,
    K_WAIT = 3'd1,
    K_CLK  = 3'd2,
    K_TIM  = 3'd3,
    K_END  = 3'd4
  } kind_e;

  typedef enum logic [4:0] {
    ST_OFF_PRE, ST_OFF_MRS, ST_OFF_WT,
    ST_SRE_PRE, ST_SRE_REF0, ST_SRE_REF1, ST_SRE_AROFF, ST_SRE_ON, ST_SRE_WT,
    ST_CLK,
    ST_SRX_WT, ST_SRX_PRE, ST_SRX_OFF, ST_SRX_ARON, ST_SRX_WT0, ST_SRX_WT1,
    ST_MR2, ST_MR2_WT, ST_MR1, ST_MR1_WT, ST_MR0, ST_MR0_WT,
    ST_TIM,
    ST_ON_MR1, ST_ON_WT, ST_RST_SET, ST_RST_SET_WT, ST_RST_CLR, ST_RST_CLR_WT,
    ST_LOCK_WT, ST_FIN_PRE, ST_LAST
  } step_e;

  typedef struct packed {
    mem_kind_e        kind;
    logic [MRW-1:0]   tgt0;
    logic [MRW-1:0]   tgt1;
    logic [MRW-1:0]   tgt2;
    logic [MRW-1:0]   cur0;
    logic [MRW-1:0]   cur1;
    logic [MRW-1:0]   cur2;
    logic [MRW-1:0]   dll_mask;
    logic [TW-1:0]    t_sre;
    logic [TW-1:0]    t_srx;
    logic [TW-1:0]    t_lock;
  } ctx_t;

  typedef struct packed {
    logic           active;
    kind_e          kind;
    cmd_e           cmd;
    logic [1:0]     mr;
    logic [MRW-1:0] data;
    logic [TW-1:0]  wlen;
  } step_t;

endpackage

// File: rtl/reclock_ctx.sv
module reclock_ctx
  import reclock_pkg::*;
#(
  parameter int T_LOCK_D2  = 2000,
  parameter int T_LOCK_D3  = 12000,
  parameter int T_LOCK_G3  = 40000,
  parameter int T_SRE_D3   = 2000,
  parameter int T_SRX_D3   = 1000,
  parameter int DLL_BIT_STD = 0,
  parameter int DLL_BIT_G3  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [1:0]     kind_i,
  input  logic [MRW-1:0] tgt0_i,
  input  logic [MRW-1:0] tgt1_i,
  input  logic [MRW-1:0] tgt2_i,
  input  logic [MRW-1:0] cur0_i,
  input  logic [MRW-1:0] cur1_i,
  input  logic [MRW-1:0] cur2_i,
  output logic           bad_o,
  output ctx_t           ctx_o
);

  localparam logic [MRW-1:0] MASK_STD = MRW'(1) << DLL_BIT_STD;
  localparam logic [MRW-1:0] MASK_G3  = MRW'(1) << DLL_BIT_G3;

  mem_kind_e kind;
  ctx_t      ctx_d;
  ctx_t      ctx_q;

  assign kind  = mem_kind_e'(kind_i);
  assign bad_o = (kind == MT_OTHER);

  always_comb begin
    ctx_d      = '0;
    ctx_d.kind = kind;
    ctx_d.tgt0 = tgt0_i;
    ctx_d.tgt1 = tgt1_i;
    ctx_d.tgt2 = tgt2_i;
    ctx_d.cur0 = cur0_i;
    ctx_d.cur1 = cur1_i;
    // the current MR2 counts only where the device reports it
    ctx_d.cur2 = (kind == MT_DDR3 || kind == MT_GDDR3) ? cur2_i : tgt2_i;
    ctx_d.dll_mask = (kind == MT_GDDR3) ? MASK_G3 : MASK_STD;
    unique case (kind)
      MT_DDR2: ctx_d.t_lock = TW'(T_LOCK_D2);
      MT_DDR3: begin
        ctx_d.t_lock = TW'(T_LOCK_D3);
        ctx_d.t_sre  = TW'(T_SRE_D3);
        ctx_d.t_srx  = TW'(T_SRX_D3);
      end
      MT_GDDR3: ctx_d.t_lock = TW'(T_LOCK_G3);
      default:  ctx_d.t_lock = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
    end else if (load_i) begin
      ctx_q <= ctx_d;
    end
  end

  assign ctx_o = ctx_q;

endmodule

// File: rtl/reclock_step_dec.sv
module reclock_step_dec
  import reclock_pkg::*;
#(
  parameter int T_MRS   = 1000,
  parameter int T_PREX  = 0,
  parameter int RST_BIT = 8
) (
  input  step_e step_i,
  input  ctx_t  ctx_i,
  output step_t info_o
);

  localparam logic [MRW-1:0] RST_MASK = MRW'(1) << RST_BIT;

  logic cur_off;
  logic tgt_off;
  logic pre_off;
  logic dll_on;
  logic is_g3;

  assign cur_off = |(ctx_i.cur1 & ctx_i.dll_mask);
  assign tgt_off = |(ctx_i.tgt1 & ctx_i.dll_mask);
  assign pre_off = !cur_off && tgt_off;
  assign dll_on  = !tgt_off;
  assign is_g3   = (ctx_i.kind == MT_GDDR3);

  always_comb begin
    info_o        = '0;
    info_o.active = 1'b1;
    info_o.kind   = K_CMD;
    info_o.cmd    = C_NOP;
    unique case (step_i)
      ST_OFF_PRE:    begin info_o.active = pre_off; info_o.cmd = C_PRECHARGE; end
      ST_OFF_MRS:    begin
        info_o.active = pre_off;
        info_o.cmd    = C_MRS;
        info_o.mr     = 2'd1;
        info_o.data   = ctx_i.cur1 | ctx_i.dll_mask;
      end
      ST_OFF_WT:     begin info_o.active = pre_off; info_o.kind = K_WAIT; info_o.wlen = TW'(T_MRS); end
      ST_SRE_PRE:    info_o.cmd = C_PRECHARGE;
      ST_SRE_REF0:   info_o.cmd = C_REFRESH;
      ST_SRE_REF1:   info_o.cmd = C_REFRESH;
      ST_SRE_AROFF:  info_o.cmd = C_AREF_OFF;
      ST_SRE_ON:     info_o.cmd = C_SREF_IN;
      ST_SRE_WT:     begin info_o.kind = K_WAIT; info_o.wlen = ctx_i.t_sre; end
      ST_CLK:        info_o.kind = K_CLK;
      ST_SRX_WT:     begin info_o.kind = K_WAIT; info_o.wlen = TW'(T_PREX); end
      ST_SRX_PRE:    info_o.cmd = C_PRECHARGE;
      ST_SRX_OFF:    info_o.cmd = C_SREF_OUT;
      ST_SRX_ARON:   info_o.cmd = C_AREF_ON;
      ST_SRX_WT0,
      ST_SRX_WT1:    begin info_o.kind = K_WAIT; info_o.wlen = ctx_i.t_srx; end
      ST_MR2:        begin
        info_o.active = (ctx_i.cur2 != ctx_i.tgt2);
        info_o.cmd    = C_MRS;
        info_o.mr     = 2'd2;
        info_o.data   = ctx_i.tgt2;
      end
      ST_MR2_WT:     begin
        info_o.active = (ctx_i.cur2 != ctx_i.tgt2);
        info_o.kind   = K_WAIT;
        info_o.wlen   = TW'(T_MRS);
      end
      ST_MR1:        begin
        info_o.active = (ctx_i.cur1 != ctx_i.tgt1);
        info_o.cmd    = C_MRS;
        info_o.mr     = 2'd1;
        // the DLL keeps its present state until the reset phase
        info_o.data   = ctx_i.tgt1 | (ctx_i.cur1 & ctx_i.dll_mask);
      end
      ST_MR1_WT:     begin
        info_o.active = (ctx_i.cur1 != ctx_i.tgt1);
        info_o.kind   = K_WAIT;
        info_o.wlen   = TW'(T_MRS);
      end
      ST_MR0:        begin
        info_o.active = (ctx_i.cur0 != ctx_i.tgt0);
        info_o.cmd    = C_MRS;
        info_o.mr     = 2'd0;
        info_o.data   = ctx_i.tgt0;
      end
      ST_MR0_WT:     begin
        info_o.active = (ctx_i.cur0 != ctx_i.tgt0);
        info_o.kind   = K_WAIT;
        info_o.wlen   = TW'(T_MRS);
      end
      ST_TIM:        info_o.kind = K_TIM;
      ST_ON_MR1:     begin
        info_o.active = dll_on && cur_off;
        info_o.cmd    = C_MRS;
        info_o.mr     = 2'd1;
        info_o.data   = ctx_i.tgt1;
      end
      ST_ON_WT:      begin
        info_o.active = dll_on && cur_off;
        info_o.kind   = K_WAIT;
        info_o.wlen   = TW'(T_MRS);
      end
      ST_RST_SET:    begin
        info_o.active = dll_on;
        info_o.cmd    = C_MRS;
        info_o.mr     = 2'd0;
        info_o.data   = ctx_i.tgt0 | RST_MASK;
      end
      ST_RST_SET_WT: begin info_o.active = dll_on; info_o.kind = K_WAIT; info_o.wlen = TW'(T_MRS); end
      ST_RST_CLR:    begin
        info_o.active = dll_on;
        info_o.cmd    = C_MRS;
        info_o.mr     = 2'd0;
        info_o.data   = ctx_i.tgt0 & ~RST_MASK;
      end
      ST_RST_CLR_WT: begin info_o.active = dll_on; info_o.kind = K_WAIT; info_o.wlen = TW'(T_MRS); end
      ST_LOCK_WT:    begin info_o.active = dll_on; info_o.kind = K_WAIT; info_o.wlen = ctx_i.t_lock; end
      ST_FIN_PRE:    begin info_o.active = dll_on && is_g3; info_o.cmd = C_PRECHARGE; end
      default:       info_o.kind = K_END;
    endcase
  end

endmodule

// File: rtl/reclock_wait_timer.sv
module reclock_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [TW-1:0] len_i,
  input  logic          tick_i,
  output logic          fin_o
);

  logic          armed_q, armed_d;
  logic [TW-1:0] cnt_q, cnt_d;

  assign fin_o = run_i && (armed_q ? (tick_i && cnt_q == TW'(1)) : (len_i == '0));

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (!run_i) begin
      armed_d = 1'b0;
    end else if (!armed_q) begin
      armed_d = (len_i != '0);
      cnt_d   = len_i;
    end else if (fin_o) begin
      armed_d = 1'b0;
    end else if (tick_i) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R11: no tick, no progress
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && armed_q && !tick_i |=> armed_q && $stable(cnt_q));

  // R11: each tick removes exactly one unit
  a_r11_step_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && armed_q && tick_i && cnt_q != TW'(1) |=> cnt_q == $past(cnt_q) - TW'(1));

endmodule

// File: rtl/dram_reclock_seq.sv
module dram_reclock_seq
  import reclock_pkg::*;
#(
  parameter int T_MRS     = 1000,
  parameter int T_PREX    = 0,
  parameter int T_LOCK_D2 = 2000,
  parameter int T_LOCK_D3 = 12000,
  parameter int T_LOCK_G3 = 40000,
  parameter int T_SRE_D3  = 2000,
  parameter int T_SRX_D3  = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  mem_kind_i,
  input  logic [31:0] tgt_mr0_i,
  input  logic [31:0] tgt_mr1_i,
  input  logic [31:0] tgt_mr2_i,
  input  logic [31:0] cur_mr0_i,
  input  logic [31:0] cur_mr1_i,
  input  logic [31:0] cur_mr2_i,
  input  logic        tick_i,
  output logic        cmd_valid_o,
  input  logic        cmd_ready_i,
  output logic [2:0]  cmd_code_o,
  output logic [1:0]  cmd_mr_o,
  output logic [31:0] cmd_data_o,
  output logic        clk_req_o,
  input  logic        clk_ack_i,
  output logic        tim_req_o,
  input  logic        tim_ack_i,
  output logic        done_o,
  output logic        err_o
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE, S_FAIL} fsm_e;

  fsm_e  state_q, state_d;
  step_e step_q, step_d, step_nx;
  ctx_t  ctx;
  step_t info;
  logic  bad;
  logic  load;
  logic  run_wait;
  logic  wait_fin;

  reclock_ctx #(
    .T_LOCK_D2(T_LOCK_D2), .T_LOCK_D3(T_LOCK_D3), .T_LOCK_G3(T_LOCK_G3),
    .T_SRE_D3(T_SRE_D3), .T_SRX_D3(T_SRX_D3)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n), .load_i(load), .kind_i(mem_kind_i),
    .tgt0_i(tgt_mr0_i), .tgt1_i(tgt_mr1_i), .tgt2_i(tgt_mr2_i),
    .cur0_i(cur_mr0_i), .cur1_i(cur_mr1_i), .cur2_i(cur_mr2_i),
    .bad_o(bad), .ctx_o(ctx)
  );

  reclock_step_dec #(.T_MRS(T_MRS), .T_PREX(T_PREX)) u_dec (
    .step_i(step_q), .ctx_i(ctx), .info_o(info)
  );

  reclock_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run_wait), .len_i(info.wlen),
    .tick_i(tick_i), .fin_o(wait_fin)
  );

  assign step_nx = step_e'(step_q + 5'd1);

  always_comb begin
    state_d     = state_q;
    step_d      = step_q;
    load        = 1'b0;
    run_wait    = 1'b0;
    cmd_valid_o = 1'b0;
    clk_req_o   = 1'b0;
    tim_req_o   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          if (bad) begin
            state_d = S_FAIL;
          end else begin
            load    = 1'b1;
            state_d = S_RUN;
            step_d  = ST_OFF_PRE;
          end
        end
      end
      S_RUN: begin
        if (!info.active) begin
          step_d = step_nx;
        end else begin
          unique case (info.kind)
            K_CMD:  begin cmd_valid_o = 1'b1; if (cmd_ready_i) step_d = step_nx; end
            K_WAIT: begin run_wait    = 1'b1; if (wait_fin)    step_d = step_nx; end
            K_CLK:  begin clk_req_o   = 1'b1; if (clk_ack_i)   step_d = step_nx; end
            K_TIM:  begin tim_req_o   = 1'b1; if (tim_ack_i)   step_d = step_nx; end
            default: state_d = S_DONE;
          endcase
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign done_o     = (state_q == S_DONE);
  assign err_o      = (state_q == S_FAIL);
  assign cmd_code_o = cmd_valid_o ? info.cmd  : 3'd0;
  assign cmd_mr_o   = cmd_valid_o ? info.mr   : 2'd0;
  assign cmd_data_o = cmd_valid_o ? info.data : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= ST_OFF_PRE;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  // R10: an offered command stays put until taken
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_code_o)
      && $stable(cmd_mr_o) && $stable(cmd_data_o));

  // R4: clock request held until acknowledged
  a_r4_clk_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clk_req_o && !clk_ack_i |=> clk_req_o);

  // R7: timing request held until acknowledged
  a_r7_tim_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tim_req_o && !tim_ack_i |=> tim_req_o);

  // R12: at most one of the outward signals at a time
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid_o, clk_req_o, tim_req_o, done_o, err_o}));

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R1: error is a single-cycle pulse followed by idle
  a_r1_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o && !cmd_valid_o && !done_o);

endmodule

// File: tb/test_dram_reclock_seq.sv
module test_dram_reclock_seq;

  localparam int CLK_PERIOD = 10;
  localparam int MRD   = 4;
  localparam int LK_D2 = 9;
  localparam int LK_D3 = 13;
  localparam int LK_G3 = 17;
  localparam int SRE3  = 6;
  localparam int XS3   = 5;
  localparam int SLACK = 24;
  localparam int WD_CYCLES = 20000;

  localparam int EV_CMD = 0, EV_CLK = 1, EV_TIM = 2, EV_DONE = 3, EV_ERR = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] mem_kind;
  logic [31:0] t0, t1, t2, c0, c1, c2;
  logic tick, ready, cack, tack;
  logic cmd_valid, clk_req, tim_req, done, err;
  logic [2:0] cmd_code;
  logic [1:0] cmd_mr;
  logic [31:0] cmd_data;

  typedef struct {
    int kind;
    int code;
    int idx;
    logic [31:0] data;
    int ticks;
    string req;
  } ev_t;

  ev_t exp_q[$];
  int pend;
  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int tcnt = 0;
  int tick_mode = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_reclock_seq #(
    .T_MRS(MRD), .T_PREX(0), .T_LOCK_D2(LK_D2), .T_LOCK_D3(LK_D3),
    .T_LOCK_G3(LK_G3), .T_SRE_D3(SRE3), .T_SRX_D3(XS3)
  ) i_dram_reclock_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mem_kind_i(mem_kind),
    .tgt_mr0_i(t0), .tgt_mr1_i(t1), .tgt_mr2_i(t2),
    .cur_mr0_i(c0), .cur_mr1_i(c1), .cur_mr2_i(c2),
    .tick_i(tick), .cmd_valid_o(cmd_valid), .cmd_ready_i(ready),
    .cmd_code_o(cmd_code), .cmd_mr_o(cmd_mr), .cmd_data_o(cmd_data),
    .clk_req_o(clk_req), .clk_ack_i(cack), .tim_req_o(tim_req), .tim_ack_i(tack),
    .done_o(done), .err_o(err)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic expect_ev(int k, int code, int idx, logic [31:0] d, string req);
    ev_t e;
    e.kind = k; e.code = code; e.idx = idx; e.data = d; e.ticks = pend; e.req = req;
    pend = 0;
    exp_q.push_back(e);
  endtask

  // reference sequence built from the requirements
  task automatic build(int mk, logic [31:0] a0, a1, a2, b0, b1, b2);
    logic [31:0] m, b2e;
    bit co, to;
    pend = 0;
    if (mk == 3) begin expect_ev(EV_ERR, 0, 0, 0, "R1"); return; end
    m   = (mk == 2) ? 32'h40 : 32'h1;
    b2e = (mk == 0) ? a2 : b2;
    co  = (b1 & m) != 0;
    to  = (a1 & m) != 0;
    if (!co && to) begin
      expect_ev(EV_CMD, 0, 0, 0, "R2");
      expect_ev(EV_CMD, 6, 1, b1 | m, "R2");
      pend += MRD;
    end
    expect_ev(EV_CMD, 0, 0, 0, "R3");
    expect_ev(EV_CMD, 1, 0, 0, "R3");
    expect_ev(EV_CMD, 1, 0, 0, "R3");
    expect_ev(EV_CMD, 2, 0, 0, "R3");
    expect_ev(EV_CMD, 4, 0, 0, "R3");
    pend += (mk == 1) ? SRE3 : 0;
    expect_ev(EV_CLK, 0, 0, 0, "R4");
    expect_ev(EV_CMD, 0, 0, 0, "R5");
    expect_ev(EV_CMD, 5, 0, 0, "R5");
    expect_ev(EV_CMD, 3, 0, 0, "R5");
    pend += 2 * ((mk == 1) ? XS3 : 0);
    if (b2e != a2) begin expect_ev(EV_CMD, 6, 2, a2, "R6"); pend += MRD; end
    if (b1 != a1)  begin expect_ev(EV_CMD, 6, 1, a1 | (b1 & m), "R6"); pend += MRD; end
    if (b0 != a0)  begin expect_ev(EV_CMD, 6, 0, a0, "R6"); pend += MRD; end
    expect_ev(EV_TIM, 0, 0, 0, "R7");
    if (!to) begin
      if (co) begin expect_ev(EV_CMD, 6, 1, a1, "R8"); pend += MRD; end
      expect_ev(EV_CMD, 6, 0, a0 | 32'h100, "R8");
      pend += MRD;
      expect_ev(EV_CMD, 6, 0, a0 & ~32'h100, "R8");
      pend += MRD + ((mk == 0) ? LK_D2 : (mk == 1) ? LK_D3 : LK_G3);
      if (mk == 2) expect_ev(EV_CMD, 0, 0, 0, "R9");
    end
    expect_ev(EV_DONE, 0, 0, 0, "R12");
  endtask

  task automatic got(int k, int code, int idx, logic [31:0] d);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R12", "unexpected event kind", 32'(k), 32'hffffffff);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == k && e.code == code && e.idx == idx && e.data == d, e.req,
          $sformatf("event k%0d code%0d idx%0d", k, code, idx),
          (e.kind == k) ? d : 32'(k), (e.kind == k) ? e.data : 32'(e.kind));
      chk(tcnt >= e.ticks && tcnt <= e.ticks + SLACK, "R11", "ticks before event",
          32'(tcnt), 32'(e.ticks));
    end
    tcnt = 0;
  endtask

  // scoreboard monitor and responder, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      ready = 1'b0; cack = 1'b0; tack = 1'b0; tick = 1'b0; tcnt = 0;
    end else begin
      cyc++;
      ready = (cyc % 3) != 0;
      cack  = clk_req && !cack;
      tack  = tim_req && !tack;
      if (cmd_valid && ready) got(EV_CMD, int'(cmd_code), int'(cmd_mr), cmd_data);
      if (clk_req && cack) begin
        chk(!cmd_valid, "R4", "command during clock request", 32'(cmd_valid), 0);
        got(EV_CLK, 0, 0, 0);
      end
      if (tim_req && tack) got(EV_TIM, 0, 0, 0);
      if (done) got(EV_DONE, 0, 0, 0);
      if (err)  got(EV_ERR, 0, 0, 0);
      tick = (tick_mode != 0) ? cyc[0] : 1'b1;
      if (tick) tcnt++;
    end
  end

  task automatic check_idle(string req);
    repeat (5) begin
      @(negedge clk);
      chk(!cmd_valid && !clk_req && !tim_req && !done && !err, req, "idle outputs",
          {27'd0, cmd_valid, clk_req, tim_req, done, err}, 0);
    end
    chk(exp_q.size() == 0, req, "missing events", 32'(exp_q.size()), 0);
  endtask

  task automatic run(int mk, logic [31:0] a0, a1, a2, b0, b1, b2, bit mid, int tm);
    tick_mode = tm;
    build(mk, a0, a1, a2, b0, b1, b2);
    @(negedge clk);
    start = 1'b1; mem_kind = 2'(mk);
    t0 = a0; t1 = a1; t2 = a2; c0 = b0; c1 = b1; c2 = b2;
    @(negedge clk);
    start = 1'b0;
    // R12: data inputs after start must not matter
    t0 = ~a0; t1 = ~a1; t2 = ~a2; c0 = ~b0; c1 = ~b1; c2 = ~b2;
    if (mid) begin
      repeat (8) @(negedge clk);
      start = 1'b1; mem_kind = 2'd3;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0 && !finished) @(negedge clk);
    check_idle((mk == 3) ? "R1" : "R12");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mem_kind = 2'd0;
    t0 = '0; t1 = '0; t2 = '0; c0 = '0; c1 = '0; c2 = '0;
    repeat (2) @(negedge clk);
    chk(!cmd_valid && !clk_req && !tim_req && !done && !err, "R13", "outputs in reset",
        {27'd0, cmd_valid, clk_req, tim_req, done, err}, 0);
    rst_n = 1'b1;
    check_idle("R13");

    // DDR3, DLL on -> off, MR2 and MR0 change
    run(1, 32'h630, 32'h45, 32'h10, 32'h520, 32'h44, 32'h08, 0, 0);
    // DDR2, DLL off -> on, MR2 ignored, start pulse mid-run
    run(0, 32'h200, 32'h40, 32'h2, 32'h200, 32'h41, 32'h1, 1, 0);
    // GDDR3, DLL off -> on on bit 6, sparse ticks
    run(2, 32'h22, 32'h03, 32'h5, 32'h11, 32'h40, 32'h5, 0, 1);
    // GDDR3, DLL stays on, MR2 differs, MR0 carries bit 8
    run(2, 32'h1a0, 32'h0, 32'h2, 32'h1a0, 32'h0, 32'h1, 0, 0);
    // unsupported type
    run(3, 32'h1, 32'h1, 32'h1, 32'h0, 32'h0, 32'h0, 0, 0);
    // DDR3, DLL stays off
    run(1, 32'h77, 32'h81, 32'h3, 32'h66, 32'h01, 32'h3, 0, 1);

    // R13: reset in the middle of a run
    build(1, 32'h630, 32'h45, 32'h10, 32'h520, 32'h44, 32'h08);
    @(negedge clk);
    start = 1'b1; mem_kind = 2'd1;
    t0 = 32'h630; t1 = 32'h45; t2 = 32'h10; c0 = 32'h520; c1 = 32'h44; c2 = 32'h08;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!cmd_valid && !clk_req && !tim_req && !done && !err, "R13", "outputs after mid-run reset",
        {27'd0, cmd_valid, clk_req, tim_req, done, err}, 0);
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    check_idle("R13");
    run(1, 32'h630, 32'h45, 32'h10, 32'h520, 32'h44, 32'h08, 0, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYCLES);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule